// File: doc/BRIEF.md
# Windowed Gamma LUT Triplet

This block applies a gamma curve to three colour channels in parallel. Every channel has its own look-up table of 2^ADDR_W entries. A channel's table address is not the whole 13-bit input sample. It is a 10-bit slice of that sample. Four slice positions exist, from the top ten bits down to the bottom ten bits. One shared window register picks the slice, and that one setting governs all three tables. A channel never gets a slice position of its own.

Table contents come in through a dedicated write port. The port carries a channel index, an address and a data word on a strobe, so loading never passes through the sample path. The window register is written through a separate strobe. Every clock that carries a valid sample set produces one registered output word per channel, and the three channels remain aligned. The memories have no reset, so the tables map onto block RAM.

Top module: `gamma_lut_triplet`

## Requirements
- R1: After a synchronous reset, `out_valid` is 0, every output word is 0 and the window code is 0.
- R2: Window code k (0..3) addresses the tables with input bits [12-k:3-k]. Code 0 uses [12:3], code 1 uses [11:2], code 2 uses [10:1] and code 3 uses [9:0].
- R3: The one window code applies to all three channels in the same cycle.
- R4: A sample set presented with `in_valid` high appears on `out_data` after exactly one clock edge. `out_valid` repeats `in_valid` one cycle later.
- R5: A window write takes effect for samples presented on the clock after the write. A sample presented in the same cycle as the write uses the previous code.
- R6: A table write with `tbl_sel` 0, 1 or 2 replaces the entry at `tbl_addr` in channel 0, 1 or 2 only. Reads in later cycles return the new word.
- R7: A table write with `tbl_sel` equal to 3 changes no table.
- R8: A read of the same entry that is being written in the same cycle returns the previous content.
- R9: While `in_valid` is low, the output words hold their last values, whatever the sample inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Window register write strobe |
| cfg_win | input | WSEL_W (2) | New window code |
| tbl_we | input | 1 | Table write strobe |
| tbl_sel | input | CSEL_W (2) | Target channel index |
| tbl_addr | input | ADDR_W (10) | Table entry to write |
| tbl_data | input | DATA_W (10) | Word to write |
| in_valid | input | 1 | Sample set valid |
| in_data | input | NUM_CH*IN_W (39) | Samples, channel c in bits [c*IN_W +: IN_W] |
| out_valid | output | 1 | Output words valid |
| out_data | output | NUM_CH*DATA_W (30) | Table words, channel c in bits [c*DATA_W +: DATA_W] |

## Verification
Two functions can fall in the same cycle. A table write can target the entry that a sample is reading, and a window write can arrive alongside a sample. The bench drives each pair in one clock. A reference model updates its tables and its window only after it has predicted that clock's read. It then checks two things on the next clock: that the colliding read returned the old word and the old window, and that only the following sample saw the new state.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;

  // number of distinct address windows inside an input sample
  function automatic int win_count(input int in_w, input int addr_w);
    return in_w - addr_w + 1;
  endfunction

  // bits needed to encode n choices (at least one)
  function automatic int sel_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/gamma_win_cfg.sv
module gamma_win_cfg #(
  parameter int WSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [WSEL_W-1:0] cfg_win,
  output logic [WSEL_W-1:0] win_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q <= '0;
    end else if (cfg_we) begin
      win_q <= cfg_win;
    end
  end

  // R5
  win_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cfg_we)) |-> (win_q == $past(cfg_win)));

  // R5
  win_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cfg_we)) |-> $stable(win_q));

endmodule

// File: rtl/gamma_win_extract.sv
module gamma_win_extract #(
  parameter int IN_W   = 13,
  parameter int ADDR_W = 10,
  parameter int WSEL_W = 2
) (
  input  logic [IN_W-1:0]   sample,
  input  logic [WSEL_W-1:0] win,
  output logic [ADDR_W-1:0] addr
);

  localparam int NWIN = gamma_lut_pkg::win_count(IN_W, ADDR_W);

  logic [ADDR_W-1:0] cand [NWIN];

  // code k takes the slice whose top bit sits k places below the MSB
  for (genvar k = 0; k < NWIN; k++) begin : g_win
    assign cand[k] = sample[IN_W-1-k -: ADDR_W];
  end

  always_comb begin
    addr = '0;
    for (int k = 0; k < NWIN; k++) begin
      if (win == WSEL_W'(k)) addr = cand[k];
    end
  end

endmodule

// File: rtl/gamma_lut_ram.sv
module gamma_lut_ram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // write port, no reset so a block RAM can hold the table
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // read port: registered, read-first on a same-address collision
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (re) begin
      rdata <= mem[raddr];
    end
  end

endmodule

// File: rtl/gamma_lut_triplet.sv
module gamma_lut_triplet #(
  parameter int NUM_CH = 3,
  parameter int IN_W   = 13,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 10,
  parameter int WSEL_W = gamma_lut_pkg::sel_width(gamma_lut_pkg::win_count(IN_W, ADDR_W)),
  parameter int CSEL_W = gamma_lut_pkg::sel_width(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we,
  input  logic [WSEL_W-1:0]        cfg_win,
  input  logic                     tbl_we,
  input  logic [CSEL_W-1:0]        tbl_sel,
  input  logic [ADDR_W-1:0]        tbl_addr,
  input  logic [DATA_W-1:0]        tbl_data,
  input  logic                     in_valid,
  input  logic [NUM_CH*IN_W-1:0]   in_data,
  output logic                     out_valid,
  output logic [NUM_CH*DATA_W-1:0] out_data
);

  logic [WSEL_W-1:0] win_q;
  logic [NUM_CH-1:0] ch_we;

  gamma_win_cfg #(.WSEL_W(WSEL_W)) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .cfg_we (cfg_we),
    .cfg_win(cfg_win),
    .win_q  (win_q)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [ADDR_W-1:0] rd_addr;

    assign ch_we[c] = tbl_we && (tbl_sel == CSEL_W'(c));

    gamma_win_extract #(
      .IN_W  (IN_W),
      .ADDR_W(ADDR_W),
      .WSEL_W(WSEL_W)
    ) u_win (
      .sample(in_data[c*IN_W +: IN_W]),
      .win   (win_q),
      .addr  (rd_addr)
    );

    gamma_lut_ram #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
    ) u_ram (
      .clk  (clk),
      .rst  (rst),
      .we   (ch_we[c]),
      .waddr(tbl_addr),
      .wdata(tbl_data),
      .re   (in_valid),
      .raddr(rd_addr),
      .rdata(out_data[c*DATA_W +: DATA_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && (out_data == '0)));

  // R4
  valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(in_valid)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_valid)) |-> $stable(out_data));

endmodule

// File: tb/gamma_lut_triplet_bench.sv
`timescale 1ns/1ps
module gamma_lut_triplet_bench;

  localparam int NC = 3;
  localparam int IW = 13;
  localparam int AW = 10;
  localparam int DW = 10;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_win = '0;
  logic tbl_we = 1'b0;
  logic [1:0] tbl_sel = '0;
  logic [AW-1:0] tbl_addr = '0;
  logic [DW-1:0] tbl_data = '0;
  logic in_valid = 1'b0;
  logic [NC*IW-1:0] in_data = '0;
  logic out_valid;
  logic [NC*DW-1:0] out_data;

  always #2 clk = ~clk;

  gamma_lut_triplet u_gamma_lut_triplet (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_win(cfg_win),
    .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model state
  int model [NC][DEPTH];
  int win_m = 0;
  int exp_d [NC];
  int exp_v = 0;

  function automatic int pattern(int ch, int a);
    return (a * 7 + ch * 311 + 5) % DEPTH;
  endfunction

  function automatic int slice(int x, int w);
    return (x >> (3 - w)) % DEPTH;
  endfunction

  task automatic check(string tag, int act, int expv, string what);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // one clock: inputs already set at a negedge; predict, advance, compare
  task automatic tick(string tag, bit iv, int s0, int s1, int s2,
                      bit cwe, int cw, bit twe, int tsel, int taddr, int tdata);
    int s [NC];
    s[0] = s0; s[1] = s1; s[2] = s2;
    in_valid = iv;
    for (int c = 0; c < NC; c++) in_data[c*IW +: IW] = IW'(s[c]);
    cfg_we = cwe; cfg_win = 2'(cw);
    tbl_we = twe; tbl_sel = 2'(tsel); tbl_addr = AW'(taddr); tbl_data = DW'(tdata);
    if (iv) for (int c = 0; c < NC; c++) exp_d[c] = model[c][slice(s[c], win_m)];
    exp_v = iv;
    if (twe && tsel < NC) model[tsel][taddr] = tdata;
    if (cwe) win_m = cw;
    @(negedge clk);
    check(tag, int'(out_valid), exp_v, "out_valid");
    for (int c = 0; c < NC; c++)
      check(tag, int'(out_data[c*DW +: DW]), exp_d[c], $sformatf("ch%0d", c));
  endtask

  task automatic idle(string tag);
    tick(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    for (int c = 0; c < NC; c++) begin
      exp_d[c] = 0;
      for (int a = 0; a < DEPTH; a++) model[c][a] = 0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state at the ports
    check("R1", int'(out_valid), 0, "out_valid after reset");
    check("R1", int'(out_data), 0, "out_data after reset");

    // R6: load every entry of every channel
    for (int c = 0; c < NC; c++)
      for (int a = 0; a < DEPTH; a++)
        tick("R6", 0, 0, 0, 0, 0, 0, 1, c, a, pattern(c, a));

    // R1: window defaults to code 0 (bits [12:3])
    tick("R1", 1, 13'h1abc, 13'h0f0f, 13'h1555, 0, 0, 0, 0, 0, 0);

    // R2, R3: every window code with distinct per-channel samples
    for (int w = 0; w < 4; w++) begin
      tick("R5", 0, 0, 0, 0, 1, w, 0, 0, 0, 0);
      tick("R2", 1, 13'h1fff, 13'h0001, 13'h1234, 0, 0, 0, 0, 0, 0);
      tick("R3", 1, 13'h0a5a, 13'h15a5, 13'h0333, 0, 0, 0, 0, 0, 0);
      tick("R2", 1, 13'h1000 >> w, 13'h0008 << w, 13'h07f8, 0, 0, 0, 0, 0, 0);
    end

    // R4: valid pattern 1,0,1,1,0 with latency one
    tick("R4", 1, 13'h0100, 13'h0200, 13'h0300, 0, 0, 0, 0, 0, 0);
    idle("R4");
    tick("R4", 1, 13'h0400, 13'h0500, 13'h0600, 0, 0, 0, 0, 0, 0);
    tick("R4", 1, 13'h0700, 13'h0800, 13'h0900, 0, 0, 0, 0, 0, 0);
    idle("R4");

    // R5: window write together with a sample; that sample uses the old code
    tick("R5", 1, 13'h1003, 13'h0ff7, 13'h0abc, 1, 0, 0, 0, 0, 0);
    tick("R5", 1, 13'h1003, 13'h0ff7, 13'h0abc, 0, 0, 0, 0, 0, 0);
    tick("R5", 1, 13'h0007, 13'h1ff8, 13'h0123, 1, 2, 0, 0, 0, 0);
    tick("R5", 1, 13'h0007, 13'h1ff8, 13'h0123, 0, 0, 0, 0, 0, 0);

    // R8 then R6: write ch1 entry 0x155 while all channels read it
    tick("R5", 0, 0, 0, 0, 1, 3, 0, 0, 0, 0);
    tick("R8", 1, 13'h0155, 13'h0155, 13'h0155, 0, 0, 1, 1, 13'h155, 10'h3c3);
    tick("R6", 1, 13'h0155, 13'h0155, 13'h0155, 0, 0, 0, 0, 0, 0);
    tick("R8", 1, 13'h0020, 13'h0020, 13'h0020, 0, 0, 1, 2, 13'h020, 10'h001);
    tick("R6", 1, 13'h0020, 13'h0020, 13'h0020, 0, 0, 0, 0, 0, 0);

    // R7: index 3 writes nothing
    tick("R7", 0, 0, 0, 0, 0, 0, 1, 3, 13'h2aa, 10'h3ff);
    tick("R7", 1, 13'h02aa, 13'h02aa, 13'h02aa, 0, 0, 0, 0, 0, 0);
    tick("R7", 1, 13'h02aa, 13'h02aa, 13'h02aa, 0, 0, 1, 3, 13'h2aa, 10'h000);
    tick("R7", 1, 13'h02aa, 13'h02aa, 13'h02aa, 0, 0, 0, 0, 0, 0);

    // R9: inputs move while invalid; outputs must hold
    tick("R9", 0, 13'h1fff, 13'h0000, 13'h1111, 0, 0, 0, 0, 0, 0);
    tick("R9", 0, 13'h0123, 13'h1abc, 13'h0777, 0, 0, 0, 0, 0, 0);
    tick("R9", 0, 13'h0fed, 13'h0444, 13'h1999, 0, 0, 1, 0, 13'h2aa, 10'h111);
    tick("R9", 1, 13'h02aa, 13'h0001, 13'h0002, 0, 0, 0, 0, 0, 0);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule